// File: doc/BRIEF.md
# AXI4-Lite to Register-Bus Bridge

This block is an AXI4-Lite slave that turns each bus transaction into a short sequence of strobes on a plain register-bank port. On the bank side it offers a byte address, a one-cycle write strobe with write data and byte enables, and a one-cycle read strobe. The bank answers a read with a one-cycle valid pulse that carries the read data. The bank may take a different number of cycles for each read. Writes are fire-and-forget: the bank gives no acknowledge.

A single state machine serves both directions. It takes one command, carries it out on the bank port and completes the AXI response before it looks at the next command. A read and a write therefore never touch the bank in the same cycle. Any bank can be attached, including one that never answers at some addresses. If the bank stays silent for longer than a configurable number of cycles, the read ends with an error response, so a missing answer cannot hang the master.

Top module: `axil_regbus_bridge`

## Requirements
- R1: When a read address and a write address are both valid in an idle cycle, only the read address is accepted (s_arready high, s_awready low). The bank read strobe comes before the bank write strobe.
- R2: Only one transaction is in progress at a time. While a transaction is in progress, s_arready and s_awready stay low, and this includes the cycles in which its response is pending.
- R3: A write raises rb_wr for exactly one cycle. This is the cycle after the write data handshake, and it never happens before both the address and the data have been accepted. In that cycle rb_wdata equals s_wdata and rb_be equals s_wstrb, with bit i of rb_be enabling byte i.
- R4: A read raises rb_rd for exactly one cycle, the cycle after the read address handshake.
- R5: If rb_rdvalid arrives L cycles after the strobe cycle, with 0 <= L <= TIMEOUT (L = 0 means the same cycle as the strobe), then s_rvalid rises L+1 cycles after the strobe cycle. s_rdata then carries the bank data and s_rresp is 2'b00.
- R6: If no rb_rdvalid arrives within TIMEOUT cycles after the strobe cycle, s_rvalid rises TIMEOUT+1 cycles after the strobe cycle, with s_rresp = 2'b10 and s_rdata = 0.
- R7: A rb_rdvalid pulse that arrives after the timeout has fired has no effect: the pending error response and the responses of later reads are unchanged.
- R8: rb_addr is the accepted byte address at full width, with its low log2(DW/8) bits forced to zero (two bits for DW = 32).
- R9: The write response has s_bresp = 2'b00 and is raised in the cycle after rb_wr. With no stalls, a write takes four cycles: the cycle after the response handshake is idle again with s_arready high.
- R10: s_rvalid and s_bvalid stay high until the matching ready is seen. s_rdata and s_rresp do not change while s_rvalid waits.
- R11: After the synchronous active-high reset, the bridge is idle: s_arready is high; s_wready, s_rvalid, s_bvalid, rb_wr and rb_rd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DW | Write data |
| s_wstrb | input | DW/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DW | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| rb_addr | output | AW | Bank byte address |
| rb_wr | output | 1 | Bank write strobe |
| rb_be | output | DW/8 | Bank byte enables |
| rb_wdata | output | DW | Bank write data |
| rb_rd | output | 1 | Bank read strobe |
| rb_rdata | input | DW | Bank read data |
| rb_rdvalid | input | 1 | Bank read data valid |

## Verification
The hardest case to reach from the ports is a bank answer that lands exactly on the timeout boundary, or just after it. The stimulus sweeps the bank latency from zero up to two cycles past TIMEOUT, with TIMEOUT set small. For each latency it predicts the response cycle, data and code. On the late-answer cases the master holds s_rready low, so that the stray valid pulse lands while the error response is still pending. Races between the two directions are provoked by presenting both addresses together with the write data already valid.

// File: rtl/axil_regbus_pkg.sv
package axil_regbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_WSTRB,
    ST_WRESP,
    ST_RSTRB,
    ST_RWAIT,
    ST_RRESP
  } br_state_t;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/axil_rb_timer.sv
module axil_rb_timer #(
  parameter int TIMEOUT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  // cycles elapsed since the strobe cycle; the strobe cycle counts as 0
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
    end else if (run && !expired) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expired = run && (cnt_q == LIMIT);

endmodule

// File: rtl/axil_rb_capture.sv
module axil_rb_capture #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_addr,
  input  logic [AW-1:0]   addr_in,
  input  logic            ld_data,
  input  logic [DW-1:0]   data_in,
  input  logic [DW/8-1:0] strb_in,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic [DW/8-1:0] strb_o
);

  localparam int SW  = DW / 8;
  localparam int LSB = $clog2(SW);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << LSB) - 1);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [SW-1:0] strb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ld_addr) begin
      addr_q <= addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      strb_q <= '0;
    end else if (ld_data) begin
      data_q <= data_in;
      strb_q <= strb_in;
    end
  end

  assign addr_o = addr_q & ~LOW_MASK;
  assign data_o = data_q;
  assign strb_o = strb_q;

endmodule

// File: rtl/axil_regbus_bridge.sv
module axil_regbus_bridge
  import axil_regbus_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int TIMEOUT = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   s_awaddr,
  input  logic            s_awvalid,
  output logic            s_awready,
  input  logic [DW-1:0]   s_wdata,
  input  logic [DW/8-1:0] s_wstrb,
  input  logic            s_wvalid,
  output logic            s_wready,
  output logic [1:0]      s_bresp,
  output logic            s_bvalid,
  input  logic            s_bready,
  input  logic [AW-1:0]   s_araddr,
  input  logic            s_arvalid,
  output logic            s_arready,
  output logic [DW-1:0]   s_rdata,
  output logic [1:0]      s_rresp,
  output logic            s_rvalid,
  input  logic            s_rready,
  output logic [AW-1:0]   rb_addr,
  output logic            rb_wr,
  output logic [DW/8-1:0] rb_be,
  output logic [DW-1:0]   rb_wdata,
  output logic            rb_rd,
  input  logic [DW-1:0]   rb_rdata,
  input  logic            rb_rdvalid
);

  br_state_t st_q, st_d;

  logic ar_hs, aw_hs, w_hs;
  logic tmo_expired;
  logic rd_window;
  logic [DW-1:0] rdata_q;
  logic [1:0]    rresp_q;

  assign s_arready = (st_q == ST_IDLE);
  assign s_awready = (st_q == ST_IDLE) && !s_arvalid;
  assign s_wready  = (st_q == ST_WDATA);
  assign s_bvalid  = (st_q == ST_WRESP);
  assign s_rvalid  = (st_q == ST_RRESP);
  assign s_bresp   = RESP_OKAY;
  assign s_rdata   = rdata_q;
  assign s_rresp   = rresp_q;
  assign rb_wr     = (st_q == ST_WSTRB);
  assign rb_rd     = (st_q == ST_RSTRB);

  assign ar_hs     = s_arvalid && s_arready;
  assign aw_hs     = s_awvalid && s_awready;
  assign w_hs      = s_wvalid && s_wready;
  assign rd_window = (st_q == ST_RSTRB) || (st_q == ST_RWAIT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (s_arvalid) st_d = ST_RSTRB;
                else if (s_awvalid) st_d = ST_WDATA;
      ST_WDATA: if (s_wvalid) st_d = ST_WSTRB;
      ST_WSTRB: st_d = ST_WRESP;
      ST_WRESP: if (s_bready) st_d = ST_IDLE;
      ST_RSTRB: st_d = rb_rdvalid ? ST_RRESP : ST_RWAIT;
      ST_RWAIT: if (rb_rdvalid || tmo_expired) st_d = ST_RRESP;
      ST_RRESP: if (s_rready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // read result: bank data wins over a timeout in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      rresp_q <= RESP_OKAY;
    end else if (rd_window && rb_rdvalid) begin
      rdata_q <= rb_rdata;
      rresp_q <= RESP_OKAY;
    end else if (tmo_expired) begin
      rdata_q <= '0;
      rresp_q <= RESP_SLVERR;
    end
  end

  axil_rb_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (st_q == ST_RSTRB),
    .run     (st_q == ST_RWAIT),
    .expired (tmo_expired)
  );

  axil_rb_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .ld_addr (ar_hs || aw_hs),
    .addr_in (ar_hs ? s_araddr : s_awaddr),
    .ld_data (w_hs),
    .data_in (s_wdata),
    .strb_in (s_wstrb),
    .addr_o  (rb_addr),
    .data_o  (rb_wdata),
    .strb_o  (rb_be)
  );

endmodule

// File: rtl/axil_regbus_bridge_chk.sv
module axil_regbus_bridge_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          s_awready,
  input logic          s_arvalid,
  input logic          s_awvalid,
  input logic          s_arready,
  input logic [1:0]    s_bresp,
  input logic          s_bvalid,
  input logic          s_bready,
  input logic [DW-1:0] s_rdata,
  input logic [1:0]    s_rresp,
  input logic          s_rvalid,
  input logic          s_rready,
  input logic [AW-1:0] rb_addr,
  input logic          rb_wr,
  input logic          rb_rd
);

  localparam int LSB = $clog2(DW / 8);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << LSB) - 1);

  // R1: simultaneous addresses lead to a read strobe next
  assert_read_first_R1: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_awvalid && s_arready) |=> rb_rd);

  // R1: bank never sees both strobes together
  assert_no_dual_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !(rb_wr && rb_rd));

  // R2: no command accepted while a response is pending
  assert_single_txn_R2: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid || s_bvalid || rb_wr || rb_rd) |-> (!s_arready && !s_awready));

  // R3 / R9: one-cycle write strobe followed by the write response
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rb_wr |=> (!rb_wr && s_bvalid));

  // R4: one-cycle read strobe
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rb_rd |=> !rb_rd);

  // R8: bank address aligned to the data width
  assert_addr_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    (rb_wr || rb_rd) |-> ((rb_addr & LOW_MASK) == '0));

  // R9: write response code
  assert_bresp_okay_R9: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> (s_bresp == 2'b00));

  // R10: read response held with stable payload
  assert_rvalid_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

  // R10: write response held
  assert_bvalid_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);

endmodule

bind axil_regbus_bridge axil_regbus_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_axil_regbus_bridge.sv
`timescale 1ns/1ps
module tb_axil_regbus_bridge;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int T  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] s_awaddr = '0;
  logic          s_awvalid = 1'b0;
  logic          s_awready;
  logic [DW-1:0] s_wdata = '0;
  logic [3:0]    s_wstrb = '0;
  logic          s_wvalid = 1'b0;
  logic          s_wready;
  logic [1:0]    s_bresp;
  logic          s_bvalid;
  logic          s_bready = 1'b0;
  logic [AW-1:0] s_araddr = '0;
  logic          s_arvalid = 1'b0;
  logic          s_arready;
  logic [DW-1:0] s_rdata;
  logic [1:0]    s_rresp;
  logic          s_rvalid;
  logic          s_rready = 1'b0;
  logic [AW-1:0] rb_addr;
  logic          rb_wr;
  logic [3:0]    rb_be;
  logic [DW-1:0] rb_wdata;
  logic          rb_rd;
  logic [DW-1:0] rb_rdata = '0;
  logic          rb_rdvalid = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  axil_regbus_bridge #(.AW(AW), .DW(DW), .TIMEOUT(T)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [31:0] data,
                          input logic [3:0] strb, input int wdelay);
    @(negedge clk);
    s_awaddr = addr; s_awvalid = 1'b1; s_bready = 1'b1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_awvalid = 1'b0;
    #1;
    for (int i = 0; i < wdelay; i++) begin
      chk(rb_wr == 1'b0, "R3 early strobe", rb_wr, 0);
      @(negedge clk); #1;
    end
    s_wdata = data; s_wstrb = strb; s_wvalid = 1'b1;
    #1;
    chk(s_wready == 1'b1, "R3 wready", s_wready, 1);
    @(negedge clk);
    s_wvalid = 1'b0;
    #1;
    chk(rb_wr == 1'b1, "R3 strobe", rb_wr, 1);
    chk(rb_wdata == data, "R3 wdata", rb_wdata, data);
    chk(rb_be == strb, "R3 byte enables", rb_be, strb);
    chk(rb_addr == (addr & 8'hFC), "R8 write addr", rb_addr, addr & 8'hFC);
    @(negedge clk); #1;
    chk(rb_wr == 1'b0, "R3 pulse width", rb_wr, 0);
    chk(s_bvalid == 1'b1, "R9 bvalid", s_bvalid, 1);
    chk(s_bresp == 2'b00, "R9 bresp", s_bresp, 0);
    @(negedge clk); #1;
    chk(s_bvalid == 1'b0, "R9 bvalid drop", s_bvalid, 0);
    chk(s_arready == 1'b1, "R9 idle after four cycles", s_arready, 1);
    s_bready = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] addr, input int lat,
                         input logic [31:0] bdata, input int rhold);
    int first;
    logic [31:0] got_d;
    logic [1:0]  got_r;
    bit ok_exp;
    first = -1; got_d = '0; got_r = '0;
    ok_exp = (lat <= T);
    @(negedge clk);
    s_araddr = addr; s_arvalid = 1'b1; s_rready = (rhold == 0);
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 1'b0;
    #1;
    chk(rb_rd == 1'b1, "R4 strobe", rb_rd, 1);
    chk(rb_addr == (addr & 8'hFC), "R8 read addr", rb_addr, addr & 8'hFC);
    for (int n = 0; n < T + lat + rhold + 5; n++) begin
      if (n > 0) begin @(negedge clk); #1; end
      if (n == 1) chk(rb_rd == 1'b0, "R4 pulse width", rb_rd, 0);
      if (s_rvalid && first < 0) begin
        first = n; got_d = s_rdata; got_r = s_rresp;
      end else if (s_rvalid && first >= 0) begin
        chk(s_rdata == got_d && s_rresp == got_r, ok_exp ? "R10 hold" : "R7 late valid ignored",
            {s_rresp, s_rdata}, {got_r, got_d});
      end
      if (first >= 0 && n >= first + rhold) s_rready = 1'b1;
      rb_rdvalid = (n == lat);
      rb_rdata   = (n == lat) ? bdata : 32'hDEAD_BEEF;
    end
    rb_rdvalid = 1'b0;
    s_rready = 1'b0;
    if (ok_exp) begin
      chk(first == lat + 1, "R5 latency", first, lat + 1);
      chk(got_d == bdata, "R5 data", got_d, bdata);
      chk(got_r == 2'b00, "R5 resp", got_r, 0);
    end else begin
      chk(first == T + 1, "R6 timeout latency", first, T + 1);
      chk(got_d == 32'h0, "R6 data", got_d, 0);
      chk(got_r == 2'b10, "R6 resp", got_r, 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(s_arready == 1'b1, "R11 arready", s_arready, 1);
    chk(s_wready == 1'b0, "R11 wready", s_wready, 0);
    chk(s_rvalid == 1'b0 && s_bvalid == 1'b0, "R11 valids", {s_rvalid, s_bvalid}, 0);
    chk(rb_wr == 1'b0 && rb_rd == 1'b0, "R11 strobes", {rb_wr, rb_rd}, 0);

    for (int s = 0; s < 16; s++)
      do_write(8'(s * 4 + (s & 3)), 32'h0101_0101 * s ^ 32'h5A00_00C3, 4'(s), s % 3);

    for (int l = 0; l <= T + 2; l++)
      do_read(8'(l * 4 + 1), l, 32'hA500_0000 + 32'h111 * l, (l > T) ? 2 : l % 3);

    // R7: after timeouts, a fresh read returns its own data
    do_read(8'h40, 1, 32'h1234_5678, 0);

    // R1 / R2: both addresses at once
    @(negedge clk);
    s_araddr = 8'h10; s_arvalid = 1'b1;
    s_awaddr = 8'h20; s_awvalid = 1'b1;
    s_wdata = 32'hCAFE_F00D; s_wstrb = 4'hF; s_wvalid = 1'b1;
    s_rready = 1'b1; s_bready = 1'b1;
    #1;
    chk(s_arready == 1'b1 && s_awready == 1'b0, "R1 read accepted first",
        {s_arready, s_awready}, 2'b10);
    @(negedge clk);
    s_arvalid = 1'b0;
    #1;
    chk(rb_rd == 1'b1 && rb_wr == 1'b0, "R1 read strobe first", {rb_rd, rb_wr}, 2'b10);
    chk(s_awready == 1'b0, "R2 aw blocked during read", s_awready, 0);
    rb_rdvalid = 1'b1; rb_rdata = 32'h0BAD_F00D;
    @(negedge clk);
    rb_rdvalid = 1'b0;
    #1;
    chk(s_rvalid == 1'b1 && s_rdata == 32'h0BAD_F00D, "R5 combined read", s_rdata, 32'h0BAD_F00D);
    chk(s_awready == 1'b0, "R2 aw blocked during response", s_awready, 0);
    @(negedge clk); #1;
    chk(s_awready == 1'b1, "R2 aw accepted after read", s_awready, 1);
    @(negedge clk);
    s_awvalid = 1'b0;
    #1;
    chk(s_wready == 1'b1, "R3 wready after aw", s_wready, 1);
    @(negedge clk);
    s_wvalid = 1'b0;
    #1;
    chk(rb_wr == 1'b1 && rb_addr == 8'h20, "R1 write follows read", rb_addr, 8'h20);
    @(negedge clk); #1;
    chk(s_bvalid == 1'b1, "R9 combined bvalid", s_bvalid, 1);
    @(negedge clk);
    s_rready = 1'b0; s_bready = 1'b0;

    // R10: write response held while bready low
    @(negedge clk);
    s_awaddr = 8'h08; s_awvalid = 1'b1; s_wvalid = 1'b1; s_wdata = 32'h1; s_wstrb = 4'h1;
    #1;
    @(negedge clk); s_awvalid = 1'b0;
    @(negedge clk); s_wvalid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(s_bvalid == 1'b1, "R10 bvalid held", s_bvalid, 1);
    end
    s_bready = 1'b1;
    @(negedge clk); #1;
    chk(s_bvalid == 1'b0, "R10 bvalid released", s_bvalid, 0);
    s_bready = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule